// File: doc/BRIEF.md
# Six-Mode Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. A 16-bit down counter runs on the block clock, is qualified or triggered by a gate input, and drives one output line whose waveform depends on the selected mode. There are six modes: terminal-count flag, retriggerable one-shot, divide-by-N rate pulse, square wave, software-started strobe and gate-started strobe. The counter can count in plain binary or in four BCD decades.

A separate register-access unit decodes the host bus, does the byte ordering and latches readback values. It hands this channel a mode code, a binary/BCD select and a 16-bit initial count, each with a one-cycle write strobe. The channel gives back the live count, the output level and a flag. The flag shows that a count has been written but has not yet been moved into the counting element.

Top module: `ivc_channel`

## Requirements
- R1: After reset, `out` is low, `count_val` is 0 and `null_count` is low.
- R2: Mode 0. A control write drives `out` low. The count written is loaded on the second rising edge after the `count_wr` cycle. `out` rises when the counter reaches 0, N clocks after the load, and stays high until the next count or control write.
- R3: In modes 0, 2, 3 and 4 the counter does not change while `gate` is low.
- R4: Mode 1. The first `gate` rising edge after the count is written loads the count and pulls `out` low for exactly N clocks. A rising edge during that pulse restarts the full N-clock low time.
- R5: Mode 1. A count written during a pulse leaves that pulse's remaining length unchanged. The next trigger uses the new value.
- R6: Mode 2. `out` goes low for one clock out of every N (N ≥ 2). The first low clock falls N−1 clocks after the load. The counter value never reads 0 for a nonzero count.
- R7: Mode 3. In every period of N clocks, `out` is high for ⌈N/2⌉ clocks and then low for ⌊N/2⌋ clocks.
- R8: Mode 4. After the load, `out` stays high, drops for exactly one clock when the counter reaches 0, and then stays high.
- R9: Mode 5. `out` stays high until a `gate` rising edge. Each rising edge then produces one low clock N clocks later.
- R10: In modes 2 and 3, `gate` low forces `out` high. A `gate` rising edge reloads the counter with the written count.
- R11: With `bcd_in`=1 the counter steps through decimal digits (nibble 0 borrows to 9). A written count of 0 counts as 65536 clocks in binary and 10000 clocks in BCD.
- R12: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R13: `null_count` is high from a control or count write until that count is loaded into the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate | input | 1 | Gate level, synchronous to clk |
| ctrl_wr | input | 1 | One-cycle strobe: mode and BCD select are written |
| mode_in | input | 3 | Mode code 0..7 |
| bcd_in | input | 1 | 1 = four BCD decades, 0 = binary |
| count_wr | input | 1 | One-cycle strobe: initial count is written |
| count_in | input | CNT_W | Initial count |
| out | output | 1 | Channel output line |
| count_val | output | CNT_W | Live counter value |
| null_count | output | 1 | Written count not yet loaded |

## Verification
A corrupted period register, or a terminal test that is one off, moves the first output edge by a whole clock. In modes 2 and 3 it also moves every later edge, so the bench measures edge positions relative to the load cycle. A wrong decade borrow shows on `count_val` one clock after the first decrement that crosses a nibble. A lost trigger or deferred-reload flag shows in the next one-shot or strobe, which is either missing or of the wrong length.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } mode_e;

    // Codes 6 and 7 drop their top bit and become rate / square.
    function automatic mode_e fold_mode(input logic [2:0] code);
        if (code[1]) return mode_e'({1'b0, code[1:0]});
        return mode_e'(code);
    endfunction

    function automatic int pow10(input int n);
        int r;
        r = 1;
        for (int i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

endpackage

// File: rtl/ivc_gate_edge.sv
module ivc_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic gate_d, gate_q;

    always_comb gate_d = gate;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end

    assign rise = gate & ~gate_q;
endmodule

// File: rtl/ivc_decrement.sv
module ivc_decrement #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] val,
    input  logic             bcd,
    output logic [CNT_W-1:0] nxt
);
    localparam int DIGITS = CNT_W / 4;

    logic [CNT_W-1:0]  bcd_nxt;
    logic [DIGITS-1:0] brw;

    assign brw[0] = 1'b1;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] d;
        assign d = val[4*i +: 4];
        assign bcd_nxt[4*i +: 4] = !brw[i] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
        if (i < DIGITS - 1) begin : g_chain
            assign brw[i+1] = brw[i] & (d == 4'd0);
        end
    end

    assign nxt = bcd ? bcd_nxt : val - CNT_W'(1);
endmodule

// File: rtl/ivc_span.sv
module ivc_span import ivc_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] val,
    input  logic             bcd,
    output logic [CNT_W:0]   span
);
    localparam int             DIGITS  = CNT_W / 4;
    localparam int             SPAN_W  = CNT_W + 1;
    localparam logic [CNT_W:0] BCD_MAX = SPAN_W'(pow10(DIGITS));
    localparam logic [CNT_W:0] BIN_MAX = {1'b1, {CNT_W{1'b0}}};

    logic [CNT_W:0] acc;

    always_comb begin
        acc = '0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            acc = acc * SPAN_W'(10) + SPAN_W'(val[4*i +: 4]);
        end
        if (val == '0) span = bcd ? BCD_MAX : BIN_MAX;
        else           span = bcd ? acc : {1'b0, val};
    end
endmodule

// File: rtl/ivc_channel.sv
module ivc_channel import ivc_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic             ctrl_wr,
    input  logic [2:0]       mode_in,
    input  logic             bcd_in,
    input  logic             count_wr,
    input  logic [CNT_W-1:0] count_in,
    output logic             out,
    output logic [CNT_W-1:0] count_val,
    output logic             null_count
);
    localparam int SPAN_W = CNT_W + 1;

    typedef struct packed {
        mode_e             mode;
        logic              bcd;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  cnt;
        logic [SPAN_W-1:0] rem;
        logic [SPAN_W-1:0] half;
        logic              loaded;
        logic              load_pend;
        logic              nul;
        logic              out;
    } chan_t;

    chan_t st_d, st_q;

    logic              rise;
    logic [CNT_W-1:0]  cnt_dec;
    logic [SPAN_W-1:0] span_w;
    logic              periodic, hw, trig, do_load, dec_en;

    ivc_gate_edge u_edge (.clk(clk), .rst_n(rst_n), .gate(gate), .rise(rise));
    ivc_decrement #(.CNT_W(CNT_W)) u_dec (.val(st_q.cnt), .bcd(st_q.bcd), .nxt(cnt_dec));
    ivc_span #(.CNT_W(CNT_W)) u_span (.val(st_q.reload), .bcd(st_q.bcd), .span(span_w));

    always_comb begin
        st_d     = st_q;
        periodic = (st_q.mode == M_RATE) || (st_q.mode == M_SQUARE);
        hw       = (st_q.mode == M_ONESHOT) || (st_q.mode == M_HWSTROBE);
        trig     = hw && rise;
        do_load  = st_q.load_pend || trig ||
                   (periodic && st_q.loaded && (rise || (gate && st_q.rem == SPAN_W'(1))));
        dec_en   = st_q.loaded && (hw || gate);

        if (do_load) begin
            st_d.cnt       = st_q.reload;
            st_d.rem       = span_w;
            st_d.half      = span_w >> 1;
            st_d.loaded    = 1'b1;
            st_d.load_pend = 1'b0;
            st_d.nul       = 1'b0;
        end else if (dec_en) begin
            st_d.cnt = cnt_dec;
            if (st_q.rem != '0) st_d.rem = st_q.rem - SPAN_W'(1);
        end

        if (count_wr) begin
            st_d.reload = count_in;
            st_d.nul    = 1'b1;
            if (st_q.mode == M_TERM || st_q.mode == M_SWSTROBE) begin
                st_d.load_pend = 1'b1;
                st_d.loaded    = 1'b0;
            end else if (periodic && !st_q.loaded) begin
                st_d.load_pend = 1'b1;
            end
        end

        if (ctrl_wr) begin
            st_d.mode      = fold_mode(mode_in);
            st_d.bcd       = bcd_in;
            st_d.loaded    = 1'b0;
            st_d.load_pend = 1'b0;
            st_d.nul       = 1'b1;
        end

        case (st_d.mode)
            M_TERM:     st_d.out = st_d.loaded && (st_d.rem == '0);
            M_ONESHOT:  st_d.out = !(st_d.loaded && (st_d.rem != '0));
            M_RATE:     st_d.out = !(gate && st_d.loaded && (st_d.rem == SPAN_W'(1)));
            M_SQUARE:   st_d.out = !gate || !st_d.loaded || (st_d.rem > st_d.half);
            default:    st_d.out = !(st_d.loaded && (st_q.rem == SPAN_W'(1)) && (st_d.rem == '0));
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= M_TERM;
        end else begin
            st_q <= st_d;
        end
    end

    assign out        = st_q.out;
    assign count_val  = st_q.cnt;
    assign null_count = st_q.nul;

    AST_M0_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_TERM && out && !ctrl_wr && !count_wr) |=> out); // R2
    AST_RATE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RATE && !out && !ctrl_wr && span_w != SPAN_W'(1)) |=> out); // R6
    AST_STROBE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == M_SWSTROBE || st_q.mode == M_HWSTROBE) && !out && !ctrl_wr) |=> out); // R8
    AST_GATE_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == M_RATE || st_q.mode == M_SQUARE) && !gate && !ctrl_wr) |=> out); // R10
    AST_NULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        count_wr |=> null_count); // R13
endmodule

// File: tb/ivc_channel_test.sv
module ivc_channel_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, gate, ctrl_wr, bcd_in, count_wr;
    logic [2:0]  mode_in;
    logic [15:0] count_in;
    logic        out, null_count;
    logic [15:0] count_val;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    ivc_channel #(.CNT_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .gate(gate), .ctrl_wr(ctrl_wr), .mode_in(mode_in),
        .bcd_in(bcd_in), .count_wr(count_wr), .count_in(count_in), .out(out),
        .count_val(count_val), .null_count(null_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [2:0] m, input logic b);
        mode_in = m; bcd_in = b; ctrl_wr = 1'b1;
        step();
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_count(input logic [15:0] n);
        count_in = n; count_wr = 1'b1;
        step();
        count_wr = 1'b0;
    endtask

    task automatic trig();
        gate = 1'b0; step();
        gate = 1'b1; step();
    endtask

    // counts consecutive low samples from the current one
    task automatic low_run(output int lows);
        lows = 0;
        while (!out && lows < 100) begin lows++; step(); end
    endtask

    // low samples and first low index over a window starting at the current sample
    task automatic scan(input int len, output int lows, output int first, output int zeros);
        lows = 0; first = -1; zeros = 0;
        for (int k = 0; k < len; k++) begin
            if (!out) begin lows++; if (first < 0) first = k; end
            if (count_val == 16'd0) zeros++;
            step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int k, lows, first, zeros, c6;
        int n0[4] = '{1, 2, 3, 7};
        int n2[3] = '{2, 3, 5};
        int n3[4] = '{4, 5, 6, 7};
        rst_n = 1'b0; gate = 1'b0; ctrl_wr = 1'b0; count_wr = 1'b0;
        mode_in = 3'd0; bcd_in = 1'b0; count_in = 16'd0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 out", out, 0);
        check("R1 count", count_val, 0);
        check("R1 null", null_count, 0);

        // mode 0 sweep
        gate = 1'b1;
        foreach (n0[i]) begin
            wr_ctrl(3'd0, 1'b0);
            check("R2 out low after control", out, 0);
            check("R13 null after control", null_count, 1);
            wr_count(16'(n0[i]));
            check("R13 null before load", null_count, 1);
            step();
            check("R2 loaded value", count_val, n0[i]);
            check("R13 null cleared", null_count, 0);
            k = 0;
            while (!out && k < 200) begin step(); k++; end
            check("R2 clocks to terminal", k, n0[i]);
            repeat (3) step();
            check("R2 out holds high", out, 1);
        end

        // R3: gate low suspends counting in mode 0
        wr_ctrl(3'd0, 1'b0); wr_count(16'd6); step();
        gate = 1'b0; step();
        check("R3 hold 1", count_val, 6);
        step();
        check("R3 hold 2", count_val, 6);
        gate = 1'b1; step();
        check("R3 resume", count_val, 5);

        // R11: zero count and decade borrow
        wr_ctrl(3'd0, 1'b0); wr_count(16'd0); step();
        check("R11 zero binary out", out, 0);
        step();
        check("R11 zero binary wrap", count_val, 16'hFFFF);
        check("R11 zero binary still low", out, 0);
        wr_ctrl(3'd0, 1'b1); wr_count(16'h0100); step(); step();
        check("R11 bcd borrow", count_val, 16'h0099);
        wr_count(16'h0000); step(); step();
        check("R11 bcd zero wrap", count_val, 16'h9999);
        wr_ctrl(3'd2, 1'b1); wr_count(16'h0000); step();
        k = 0;
        while (out && k < 20000) begin step(); k++; end
        check("R11 bcd zero period", k, 9999);

        // R6: rate generator sweep
        foreach (n2[i]) begin
            wr_ctrl(3'd2, 1'b0); wr_count(16'(n2[i])); step();
            scan(4 * n2[i], lows, first, zeros);
            check("R6 low count", lows, 4);
            check("R6 first low", first, n2[i] - 1);
            check("R6 never zero", zeros, 0);
        end

        // R7: square wave sweep
        foreach (n3[i]) begin
            wr_ctrl(3'd3, 1'b0); wr_count(16'(n3[i])); step();
            scan(2 * n3[i], lows, first, zeros);
            check("R7 high clocks", 2 * n3[i] - lows, 2 * ((n3[i] + 1) / 2));
            check("R7 first low", first, (n3[i] + 1) / 2);
        end

        // R12: aliases
        wr_ctrl(3'd6, 1'b0); wr_count(16'd3); step();
        scan(9, lows, first, zeros);
        check("R12 mode 6 as rate", first, 2);
        wr_ctrl(3'd7, 1'b0); wr_count(16'd5); step();
        scan(5, lows, first, zeros);
        check("R12 mode 7 as square", first, 3);

        // R10: gate in square mode
        wr_ctrl(3'd3, 1'b0); wr_count(16'd8); step();
        repeat (5) step();
        check("R7 low phase", out, 0);
        gate = 1'b0; step();
        check("R10 forced high", out, 1);
        c6 = count_val;
        step();
        check("R10 count held", count_val, c6);
        gate = 1'b1; step();
        check("R10 reload on rise", count_val, 8);
        check("R10 out high after reload", out, 1);

        // R8: software strobe
        wr_ctrl(3'd4, 1'b0); wr_count(16'd3); step();
        scan(13, lows, first, zeros);
        check("R8 single strobe", lows, 1);
        check("R8 strobe position", first, 3);

        // R9: hardware strobe
        gate = 1'b0;
        wr_ctrl(3'd5, 1'b0); wr_count(16'd3);
        scan(6, lows, first, zeros);
        check("R9 no strobe before trigger", lows, 0);
        check("R13 null until trigger", null_count, 1);
        trig();
        check("R13 null cleared by trigger", null_count, 0);
        scan(9, lows, first, zeros);
        check("R9 first strobe", first, 3);
        check("R9 one strobe", lows, 1);
        trig();
        scan(9, lows, first, zeros);
        check("R9 second strobe", first, 3);

        // R4 / R5: one-shot
        gate = 1'b0;
        wr_ctrl(3'd1, 1'b0);
        check("R4 idle high", out, 1);
        wr_count(16'd4);
        trig(); low_run(lows);
        check("R4 pulse length", lows, 4);
        trig(); wr_count(16'd7); low_run(lows);
        check("R5 pulse unaffected by write", lows, 3);
        trig(); low_run(lows);
        check("R5 new count on trigger", lows, 7);
        trig(); step(); gate = 1'b0; step(); gate = 1'b1; step();
        check("R4 low at retrigger", out, 0);
        low_run(lows);
        check("R4 retrigger restarts", lows, 7);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule